// File: doc/BRIEF.md
# Seven-Segment Space-Vector Switching Sequencer

This block turns one switching period's worth of dwell times into gate commands for a three-leg inverter. It takes a sector number from 1 to 6 and three times counted in clock ticks: the leading active time `tk_i`, the trailing active time `tk1_i` and the zero-vector time `tz_i`. A ramp counter runs once over the period. Across that span the three high-side commands step through a mirrored seven-part pattern. The pattern opens with the all-off vector, moves through two active vectors to the all-on vector in the middle, and then retraces the same steps back to all-off. The low-side commands are the bitwise inverse of the high-side ones.

The sector and the three times are captured only at the instant the ramp restarts, so a controller upstream may update them at any time. A one-cycle pulse marks the first tick of every period. In even sectors the two active times are applied in swapped order. As a result, with non-degenerate times, each step between parts flips a single leg. A sector code outside 1..6 produces a period with every leg off.

Top module: `vec_seq7`

## Requirements
- R1: While `rst_ni` is low, `upper_o` is 000, `lower_o` is 111 and `sop_o` is 0.
- R2: A period lasts `tk_i + tk1_i + tz_i` ticks, or 1 tick when that sum is 0. `sop_o` is high on the first tick of each period and low on every other tick.
- R3: The period is divided into these parts, in order: zero for floor(tz/4) ticks, lead vector for floor(L/2), trail vector for floor(T/2), all-on (111) for floor(tz/2), trail vector for floor(T/2), lead vector for floor(L/2), then zero for the rest of the period. All rounding residue goes into that last zero part.
- R4: Bits of `upper_o` are [2]=leg A, [1]=leg B, [0]=leg C. The (lead, trail) vector pair for each sector is: 1 → (100, 110), 2 → (010, 110), 3 → (010, 011), 4 → (001, 011), 5 → (001, 101), 6 → (100, 101).
- R5: In sectors 1, 3 and 5 the lead time L is `tk_i` and the trail time T is `tk1_i`. In sectors 2, 4 and 6, L is `tk1_i` and T is `tk_i`.
- R6: `lower_o` always equals the bitwise inverse of `upper_o`.
- R7: Sector and times are captured only when the ramp restarts. A change to them during a period has no effect until the next period.
- R8: A sector code of 0 or 7 keeps `upper_o` at 000 for the whole period. The period length still follows R2.
- R9: When both active times are at least 2 and `tz_i` is at least 4, every change of `upper_o` within a period flips exactly one leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sector_i | input | 3 | Sector code, 1..6 valid |
| tk_i | input | TW | Active time Tk in ticks |
| tk1_i | input | TW | Active time Tk+1 in ticks |
| tz_i | input | TW | Zero-vector time T0 in ticks |
| sop_o | output | 1 | Pulse on the first tick of each period |
| upper_o | output | 3 | High-side commands, [2]=A, [1]=B, [0]=C |
| lower_o | output | 3 | Low-side commands, inverse of `upper_o` |

## Verification
The assertions assume that the sector and time inputs hold no unknown values once reset ends. They also assume the captured parameters reach the outputs only at a ramp restart. The bench supports both assumptions: it drives every input on a falling edge and sets all of them before reset is released. It holds each setting for two full periods before comparing, except in the one scenario that deliberately changes the inputs at a period's first tick to check that they are ignored until the next period. The single-leg property is checked only with times that meet the R9 minimums, because zero-length parts legitimately cause two-leg jumps.

// File: rtl/svs_pkg.sv
package svs_pkg;

  typedef logic [2:0] leg_t;

  typedef enum logic [2:0] {
    SEG_Z0  = 3'd0,
    SEG_L0  = 3'd1,
    SEG_T0  = 3'd2,
    SEG_ALL = 3'd3,
    SEG_T1  = 3'd4,
    SEG_L1  = 3'd5,
    SEG_Z1  = 3'd6
  } seg_e;

  function automatic logic sector_valid(input logic [2:0] s);
    return (s != 3'd0) && (s != 3'd7);
  endfunction

  // first active vector entered from the zero vector
  function automatic leg_t lead_vec(input logic [2:0] s);
    case (s)
      3'd1, 3'd6: return 3'b100;
      3'd2, 3'd3: return 3'b010;
      3'd4, 3'd5: return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

  // second active vector, adjacent to the all-on vector
  function automatic leg_t trail_vec(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return 3'b110;
      3'd3, 3'd4: return 3'b011;
      3'd5, 3'd6: return 3'b101;
      default:    return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/svs_rst_sync.sv
module svs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/svs_bounds.sv
module svs_bounds
  import svs_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic [2:0]           sector_i,
  input  logic [TW-1:0]        tk_i,
  input  logic [TW-1:0]        tk1_i,
  input  logic [TW-1:0]        tz_i,
  output logic [5:0][TW+1:0]   edges_o,
  output logic [TW+1:0]        last_o,
  output leg_t                 lead_o,
  output leg_t                 trail_o,
  output logic                 ok_o
);
  localparam int SW = TW + 2;

  logic [TW-1:0]       lead_t, trail_t;
  logic [5:0][SW-1:0]  inc;
  logic [SW-1:0]       acc;
  logic [SW-1:0]       total;

  always_comb begin
    // R5: odd sectors apply Tk first, even sectors Tk+1 first
    if (sector_i[0]) begin
      lead_t  = tk_i;
      trail_t = tk1_i;
    end else begin
      lead_t  = tk1_i;
      trail_t = tk_i;
    end
    inc[0] = SW'(tz_i >> 2);
    inc[1] = SW'(lead_t >> 1);
    inc[2] = SW'(trail_t >> 1);
    inc[3] = SW'(tz_i >> 1);
    inc[4] = SW'(trail_t >> 1);
    inc[5] = SW'(lead_t >> 1);
    acc = '0;
    for (int i = 0; i < 6; i++) begin
      acc        = acc + inc[i];
      edges_o[i] = acc;
    end
    total  = SW'(tk_i) + SW'(tk1_i) + SW'(tz_i);
    last_o = (total == '0) ? '0 : total - SW'(1);
    lead_o  = lead_vec(sector_i);
    trail_o = trail_vec(sector_i);
    ok_o    = sector_valid(sector_i);
  end
endmodule

// File: rtl/svs_ramp.sv
module svs_ramp
  import svs_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [5:0][TW+1:0] edges_i,
  input  logic [TW+1:0]      last_i,
  input  leg_t               lead_i,
  input  leg_t               trail_i,
  input  logic               ok_i,
  output logic [TW+1:0]      cnt_o,
  output logic [5:0][TW+1:0] edges_o,
  output leg_t               lead_o,
  output leg_t               trail_o,
  output logic               ok_o
);
  localparam int SW = TW + 2;

  logic [SW-1:0]      cnt_q, cnt_d;
  logic [SW-1:0]      last_q;
  logic [5:0][SW-1:0] edges_q;
  leg_t               lead_q, trail_q;
  logic               ok_q;
  logic               load_en;

  assign load_en = (cnt_q == last_q);

  always_comb begin
    cnt_d = load_en ? '0 : cnt_q + SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R7: timing is captured only on the restart cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      edges_q <= '0;
      lead_q  <= '0;
      trail_q <= '0;
      ok_q    <= 1'b0;
    end else if (load_en) begin
      last_q  <= last_i;
      edges_q <= edges_i;
      lead_q  <= lead_i;
      trail_q <= trail_i;
      ok_q    <= ok_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign edges_o = edges_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
  assign ok_o    = ok_q;

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> (cnt_q == '0));

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_q);

  assert_hold_mid_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en |=> ($stable(last_q) && $stable(edges_q) && $stable(lead_q)
                  && $stable(trail_q) && $stable(ok_q)));
endmodule

// File: rtl/svs_pattern.sv
module svs_pattern
  import svs_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TW+1:0]      cnt_i,
  input  logic [5:0][TW+1:0] edges_i,
  input  leg_t               lead_i,
  input  leg_t               trail_i,
  input  logic               ok_i,
  output leg_t               upper_o,
  output leg_t               lower_o,
  output logic               sop_o
);
  seg_e seg;
  leg_t vec_d;
  logic sop_d;
  leg_t upper_q, lower_q;
  logic sop_q;

  // smallest edge above the tick selects the part
  always_comb begin
    seg = SEG_Z1;
    for (int i = 5; i >= 0; i--) begin
      if (cnt_i < edges_i[i]) seg = seg_e'(3'(i));
    end
  end

  always_comb begin
    vec_d = 3'b000;
    if (ok_i) begin
      case (seg)
        SEG_L0, SEG_L1: vec_d = lead_i;
        SEG_T0, SEG_T1: vec_d = trail_i;
        SEG_ALL:        vec_d = 3'b111;
        default:        vec_d = 3'b000;
      endcase
    end
    sop_d = (cnt_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= 3'b000;
      lower_q <= 3'b111;
      sop_q   <= 1'b0;
    end else begin
      upper_q <= vec_d;
      lower_q <= ~vec_d;
      sop_q   <= sop_d;
    end
  end

  assign upper_o = upper_q;
  assign lower_o = lower_q;
  assign sop_o   = sop_q;

  assert_complement_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lower_q == ~upper_q);

  assert_fault_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_i |=> (upper_q == 3'b000));

  assert_centre_all_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_i && seg == SEG_ALL) |=> (upper_q == 3'b111));
endmodule

// File: rtl/vec_seq7.sv
module vec_seq7
  import svs_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    sector_i,
  input  logic [TW-1:0] tk_i,
  input  logic [TW-1:0] tk1_i,
  input  logic [TW-1:0] tz_i,
  output logic          sop_o,
  output logic [2:0]    upper_o,
  output logic [2:0]    lower_o
);
  localparam int SW = TW + 2;

  logic               rst_n_int;
  logic [5:0][SW-1:0] edges_c, edges_q;
  logic [SW-1:0]      last_c, cnt;
  leg_t               lead_c, trail_c, lead_q, trail_q;
  logic               ok_c, ok_q;

  svs_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  svs_bounds #(.TW(TW)) u_bounds (
    .sector_i (sector_i),
    .tk_i     (tk_i),
    .tk1_i    (tk1_i),
    .tz_i     (tz_i),
    .edges_o  (edges_c),
    .last_o   (last_c),
    .lead_o   (lead_c),
    .trail_o  (trail_c),
    .ok_o     (ok_c)
  );

  svs_ramp #(.TW(TW)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .edges_i (edges_c),
    .last_i  (last_c),
    .lead_i  (lead_c),
    .trail_i (trail_c),
    .ok_i    (ok_c),
    .cnt_o   (cnt),
    .edges_o (edges_q),
    .lead_o  (lead_q),
    .trail_o (trail_q),
    .ok_o    (ok_q)
  );

  svs_pattern #(.TW(TW)) u_pattern (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .cnt_i   (cnt),
    .edges_i (edges_q),
    .lead_i  (lead_q),
    .trail_i (trail_q),
    .ok_i    (ok_q),
    .upper_o (upper_o),
    .lower_o (lower_o),
    .sop_o   (sop_o)
  );
endmodule

// File: tb/tb_vec_seq7.sv
module tb_vec_seq7;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [2:0]    sector_i;
  logic [TW-1:0] tk_i, tk1_i, tz_i;
  logic          sop_o;
  logic [2:0]    upper_o, lower_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vec_seq7 #(.TW(TW)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .sector_i (sector_i),
    .tk_i (tk_i), .tk1_i (tk1_i), .tz_i (tz_i),
    .sop_o (sop_o), .upper_o (upper_o), .lower_o (lower_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected high-side vector from the requirement text (R3, R4, R5, R8)
  function automatic logic [2:0] ev(input int s, input int tk, input int tk1,
                                    input int tz, input int t);
    int l, r, q, a, b, h;
    logic [2:0] v1, v2;
    if (s < 1 || s > 6) return 3'b000;
    l = (s % 2 == 1) ? tk : tk1;
    r = (s % 2 == 1) ? tk1 : tk;
    case (s)
      1: begin v1 = 3'b100; v2 = 3'b110; end
      2: begin v1 = 3'b010; v2 = 3'b110; end
      3: begin v1 = 3'b010; v2 = 3'b011; end
      4: begin v1 = 3'b001; v2 = 3'b011; end
      5: begin v1 = 3'b001; v2 = 3'b101; end
      default: begin v1 = 3'b100; v2 = 3'b101; end
    endcase
    q = tz / 4; a = l / 2; b = r / 2; h = tz / 2;
    if (t < q)                 return 3'b000;
    if (t < q + a)             return v1;
    if (t < q + a + b)         return v2;
    if (t < q + a + b + h)     return 3'b111;
    if (t < q + a + 2*b + h)   return v2;
    if (t < q + 2*a + 2*b + h) return v1;
    return 3'b000;
  endfunction

  task automatic apply(input int s, input int a, input int b, input int z);
    sector_i = 3'(s); tk_i = TW'(a); tk1_i = TW'(b); tz_i = TW'(z);
  endtask

  task automatic wait_sop();
    do @(negedge clk); while (!sop_o);
  endtask

  task automatic sync2();
    wait_sop();
    wait_sop();
  endtask

  // entered on the negedge showing tick 0; leaves on the next period's tick 0
  task automatic check_from_sop(input int s, input int a, input int b, input int z,
                                input string tag);
    int p;
    int multi;
    logic [2:0] prev;
    logic [2:0] e;
    p = (a + b + z == 0) ? 1 : a + b + z;
    multi = 0;
    prev = 3'b000;
    for (int t = 0; t < p; t++) begin
      if (t > 0) @(negedge clk);
      e = ev(s, a, b, z, t);
      chk(upper_o == e, tag, int'(upper_o), int'(e));
      chk(lower_o == ~upper_o, "R6 lower inverse", int'(lower_o), int'(~upper_o));
      chk(sop_o == (t == 0), "R2 sop position", int'(sop_o), int'(t == 0));
      if (t > 0 && $countones(upper_o ^ prev) > 1) multi++;
      prev = upper_o;
    end
    @(negedge clk);
    chk(sop_o == 1'b1, "R2 period length", int'(sop_o), 1);
    if (s >= 1 && s <= 6 && a >= 2 && b >= 2 && z >= 4)
      chk(multi == 0, "R9 single-leg steps", multi, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    apply(1, 6, 4, 8);
    repeat (3) @(negedge clk);
    chk(upper_o == 3'b000, "R1 reset upper", int'(upper_o), 0);
    chk(lower_o == 3'b111, "R1 reset lower", int'(lower_o), 7);
    chk(sop_o == 1'b0, "R1 reset sop", int'(sop_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_sectors();
    for (int s = 1; s <= 6; s++) begin
      apply(s, 6, 4, 8);
      sync2();
      check_from_sop(s, 6, 4, 8, "R4/R5/R3 sector pattern");
    end
  endtask

  task automatic t_odd_times();
    apply(3, 5, 3, 7);
    sync2();
    check_from_sop(3, 5, 3, 7, "R3 rounding residue");
    apply(6, 3, 9, 6);
    sync2();
    check_from_sop(6, 3, 9, 6, "R3/R5 odd even-sector");
  endtask

  task automatic t_zero();
    apply(2, 0, 0, 0);
    sync2();
    check_from_sop(2, 0, 0, 0, "R2 empty period");
    check_from_sop(2, 0, 0, 0, "R2 empty period repeat");
  endtask

  task automatic t_fault();
    apply(0, 3, 5, 8);
    sync2();
    check_from_sop(0, 3, 5, 8, "R8 sector 0 off");
    apply(7, 4, 4, 4);
    sync2();
    check_from_sop(7, 4, 4, 4, "R8 sector 7 off");
  endtask

  task automatic t_midchange();
    apply(1, 6, 4, 8);
    sync2();
    apply(4, 2, 10, 12);
    check_from_sop(1, 6, 4, 8, "R7 held mid-period");
    check_from_sop(4, 2, 10, 12, "R7 loaded next period");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sectors();
    t_odd_times();
    t_zero();
    t_fault();
    t_midchange();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule